// File: doc/BRIEF.md
# Seconds Counter Real-Time Clock with Alarm

This peripheral keeps time as a plain 32-bit count of seconds, bumped once per second by a tick that a prescaler derives from the bus clock. Software sets the time by writing a new count. It arms an alarm by writing a 32-bit compare value, and it steers a single level interrupt through a one-bit enable. Raw and enabled status can each be read. Writing to a dedicated address clears the alarm.

The block sits on a 32-bit register bus with select, enable and write strobes, in the style of APB. A write takes effect on the clock edge where select and enable are both high. Read data is combinational from the word address. The window is 4 KB. The top eight words hold fixed identification bytes, and every address outside the mapped words reads zero and ignores writes.

Top module: `sec_rtc`

## Requirements
- R1: After reset, the count, compare value, load value, interrupt enable and raw alarm status are all zero, and `irq` is low.
- R2: The count goes up by one every `TICK_DIV` bus clocks. It wraps from 0xFFFFFFFF to 0.
- R3: A write to word 0x08 sets the count to the written value and restarts the prescaler, so the next increment comes `TICK_DIV` clocks later. A read of 0x08 returns the last value written there.
- R4: Word 0x04 holds the compare value and reads it back. The raw alarm status (bit 0 of word 0x14) is set by the tick that makes the count equal to the compare value.
- R5: A write to 0x04 or 0x08 that leaves the count equal to the compare value sets the raw status at that same edge.
- R6: Word 0x10 stores only bit 0 of the written data as the interrupt enable. Reads return it zero-extended.
- R7: Word 0x18 reads raw status AND enable, and `irq` carries the same value.
- R8: Any write to word 0x1C clears the raw status, whatever the data. If an alarm is set in the same cycle, the set wins.
- R9: Word 0x0C always reads 1, and writes to it change nothing.
- R10: Writes to 0x00, 0x14, 0x18 and to unmapped words have no effect. Reads of 0x1C and of unmapped words return 0.
- R11: Words 0xFE0 to 0xFFC return, in ascending address order, the bytes 0x31, 0x10, 0x14, 0x00, 0x0D, 0xF0, 0x05, 0xB1.
- R12: A compare value below the current count fires only after the count wraps through zero and reaches it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock, which also drives the prescaler |
| rst_n | input | 1 | Active-low synchronous reset |
| psel | input | 1 | Peripheral select |
| penable | input | 1 | Access phase strobe |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 12 | Byte address in the 4 KB window; bits 1:0 are ignored |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, combinational from `paddr` |
| irq | output | 1 | Level alarm interrupt, raw status AND enable |

## Verification
Register writes and alarm set or clear show on the read port and on `irq` right after the write edge. Reads add no delay. After a load, or after reset is released, the n-th increment lands on edge n·`TICK_DIV`. The bench drives each write as a one-edge access and counts edges from a fresh load. This puts every tick either clear of a write or deliberately on the same edge as one, for the set-beats-clear case. Reads take a picosecond each just after a falling edge, so a sweep of all 1024 words sees one frozen state.

// File: rtl/rtc_pkg.sv
`timescale 1ns/1ps
package rtc_pkg;
  localparam int DW = 32;
  localparam int AW = 10; // word index width in a 4 KB window

  localparam logic [AW-1:0] IDX_COUNT = 10'd0;
  localparam logic [AW-1:0] IDX_MATCH = 10'd1;
  localparam logic [AW-1:0] IDX_LOAD  = 10'd2;
  localparam logic [AW-1:0] IDX_CTRL  = 10'd3;
  localparam logic [AW-1:0] IDX_MASK  = 10'd4;
  localparam logic [AW-1:0] IDX_RAW   = 10'd5;
  localparam logic [AW-1:0] IDX_MIS   = 10'd6;
  localparam logic [AW-1:0] IDX_CLR   = 10'd7;
  localparam logic [AW-4:0] ID_BLOCK  = 7'h7F; // words 0x3F8..0x3FF

  function automatic logic [7:0] id_byte(input logic [2:0] pos);
    case (pos)
      3'd0: id_byte = 8'h31;
      3'd1: id_byte = 8'h10;
      3'd2: id_byte = 8'h14;
      3'd3: id_byte = 8'h00;
      3'd4: id_byte = 8'h0D;
      3'd5: id_byte = 8'hF0;
      3'd6: id_byte = 8'h05;
      default: id_byte = 8'hB1;
    endcase
  endfunction

  function automatic logic [DW-1:0] next_count(input logic [DW-1:0] cur,
                                               input logic step,
                                               input logic ld,
                                               input logic [DW-1:0] ld_val);
    if (ld) next_count = ld_val;
    else if (step) next_count = cur + 1'b1;
    else next_count = cur;
  endfunction

  function automatic logic alarm_hit(input logic [DW-1:0] cnt,
                                     input logic [DW-1:0] cmp);
    alarm_hit = (cnt == cmp);
  endfunction
endpackage

// File: rtl/rtc_prescaler.sv
`timescale 1ns/1ps
module rtc_prescaler #(
  parameter int DIV = 50_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic tick
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;

  generate
    if (DIV <= 1) begin : g_pass
      logic unused_pins;
      assign unused_pins = ^{clk, rst_n, restart};
      assign tick = 1'b1;
    end else begin : g_div
      localparam logic [PW-1:0] LAST = PW'(DIV - 1);
      logic [PW-1:0] phase;

      always_ff @(posedge clk) begin
        if (!rst_n || restart || phase == LAST) phase <= '0;
        else phase <= phase + 1'b1;
      end

      assign tick = (phase == LAST);

      assert_tick_spacing_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    end
  endgenerate
endmodule

// File: rtl/rtc_timebase.sv
`timescale 1ns/1ps
module rtc_timebase
  import rtc_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          load_we,
  input  logic          match_we,
  input  logic          clr_we,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] count,
  output logic [DW-1:0] match,
  output logic          raw,
  output logic          alarm_set
);
  logic [DW-1:0] count_nx, match_nx;
  logic          evaluate;

  always_comb begin
    count_nx  = next_count(count, tick, load_we, wdata);
    match_nx  = match_we ? wdata : match;
    evaluate  = tick | load_we | match_we;
    alarm_set = evaluate && alarm_hit(count_nx, match_nx);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= '0;
      match <= '0;
      raw   <= 1'b0;
    end else begin
      count <= count_nx;
      match <= match_nx;
      if (alarm_set) raw <= 1'b1;
      else if (clr_we) raw <= 1'b0;
    end
  end

  assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !load_we) |=> count == $past(count) + 32'd1);
  assert_load_value_R3: assert property (@(posedge clk) disable iff (!rst_n)
    load_we |=> count == $past(wdata));
  assert_alarm_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_set |=> raw);
  assert_raw_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(raw) |-> $past(clr_we));
endmodule

// File: rtl/rtc_regs.sv
`timescale 1ns/1ps
module rtc_regs
  import rtc_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [AW-1:0] idx,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] count,
  input  logic [DW-1:0] match,
  input  logic          raw,
  output logic          load_we,
  output logic          match_we,
  output logic          clr_we,
  output logic          mask_we,
  output logic          mask,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] load_q;

  assign load_we  = wr && idx == IDX_LOAD;
  assign match_we = wr && idx == IDX_MATCH;
  assign clr_we   = wr && idx == IDX_CLR;
  assign mask_we  = wr && idx == IDX_MASK;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      load_q <= '0;
      mask   <= 1'b0;
    end else begin
      if (load_we) load_q <= wdata;
      if (mask_we) mask <= wdata[0];
    end
  end

  always_comb begin
    rdata = '0;
    if (idx[AW-1:3] == ID_BLOCK) begin
      rdata = {24'd0, id_byte(idx[2:0])};
    end else begin
      case (idx)
        IDX_COUNT: rdata = count;
        IDX_MATCH: rdata = match;
        IDX_LOAD:  rdata = load_q;
        IDX_CTRL:  rdata = 32'd1;
        IDX_MASK:  rdata = {31'd0, mask};
        IDX_RAW:   rdata = {31'd0, raw};
        IDX_MIS:   rdata = {31'd0, raw & mask};
        default:   rdata = '0;
      endcase
    end
  end

  assert_mask_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !mask_we |=> mask == $past(mask));
endmodule

// File: rtl/sec_rtc.sv
`timescale 1ns/1ps
module sec_rtc
  import rtc_pkg::*;
#(
  parameter int TICK_DIV = 50_000_000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        psel,
  input  logic        penable,
  input  logic        pwrite,
  input  logic [11:0] paddr,
  input  logic [31:0] pwdata,
  output logic [31:0] prdata,
  output logic        irq
);
  logic          wr, tick;
  logic          load_we, match_we, clr_we, mask_we, mask;
  logic          raw, alarm_set;
  logic [DW-1:0] count, match;
  logic          unused_lsb;

  assign wr = psel & penable & pwrite;
  assign unused_lsb = ^paddr[1:0];

  rtc_prescaler #(.DIV(TICK_DIV)) u_pre (
    .clk(clk), .rst_n(rst_n), .restart(load_we), .tick(tick)
  );

  rtc_timebase u_tb (
    .clk(clk), .rst_n(rst_n), .tick(tick), .load_we(load_we),
    .match_we(match_we), .clr_we(clr_we), .wdata(pwdata),
    .count(count), .match(match), .raw(raw), .alarm_set(alarm_set)
  );

  rtc_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr(wr), .idx(paddr[11:2]), .wdata(pwdata),
    .count(count), .match(match), .raw(raw),
    .load_we(load_we), .match_we(match_we), .clr_we(clr_we),
    .mask_we(mask_we), .mask(mask), .rdata(prdata)
  );

  assign irq = raw & mask;

  assert_irq_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($past(alarm_set) || $past(mask_we)));
  assert_irq_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> ($past(clr_we) || $past(mask_we)));
endmodule

// File: tb/sec_rtc_test.sv
`timescale 1ns/1ps
module sec_rtc_test;
  localparam int D = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [11:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic        irq;
  int          total = 0, bad = 0;
  bit          done = 0;

  sec_rtc #(.TICK_DIV(D)) uut (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata),
    .prdata(prdata), .irq(irq)
  );

  always #10 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h expected=%h", tag, got, exp);
    end
  endtask

  // one-edge write, called just after a falling edge
  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    psel = 1; penable = 1; pwrite = 1; paddr = a; pwdata = d;
    @(negedge clk);
    psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    paddr = a; psel = 1; pwrite = 0;
    #0.001;
    d = prdata;
    psel = 0;
  endtask

  task automatic rchk(input string tag, input logic [11:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    chk(tag, v, exp);
  endtask

  function automatic logic [31:0] id_exp(input int k);
    logic [7:0] t [8] = '{8'h31, 8'h10, 8'h14, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
    return {24'd0, t[k]};
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    rchk("R1 count", 12'h000, 0);
    rchk("R1 match", 12'h004, 0);
    rchk("R1 load", 12'h008, 0);
    rchk("R1 mask", 12'h010, 0);
    rchk("R1 raw", 12'h014, 0);
    chk("R1 irq", {31'd0, irq}, 0);
    rchk("R9 ctrl", 12'h00C, 1);
    // R2 ticks from reset
    repeat (3*D) @(negedge clk);
    rchk("R2 count after 3 s", 12'h000, 3);
    rchk("R2 raw quiet", 12'h014, 0);
    // R3 load and restart
    wr(12'h008, 32'h1000);
    rchk("R3 count loaded", 12'h000, 32'h1000);
    rchk("R3 load readback", 12'h008, 32'h1000);
    repeat (5*D) @(negedge clk);
    rchk("R3 count +5", 12'h000, 32'h1005);
    repeat (D-1) @(negedge clk);
    rchk("R2 before tick", 12'h000, 32'h1005);
    @(negedge clk);
    rchk("R2 at tick", 12'h000, 32'h1006);
    // R4 tick-driven match
    wr(12'h008, 32'h1000);
    wr(12'h004, 32'h1002);
    rchk("R4 match readback", 12'h004, 32'h1002);
    repeat (2*D-2) @(negedge clk);
    rchk("R4 count one short", 12'h000, 32'h1001);
    rchk("R4 raw not yet", 12'h014, 0);
    @(negedge clk);
    rchk("R4 raw set", 12'h014, 1);
    rchk("R7 mis masked", 12'h018, 0);
    chk("R7 irq masked", {31'd0, irq}, 0);
    // R6 / R7 enable bit
    for (int i = 0; i < 8; i++) begin
      logic [31:0] pat;
      pat = 32'h9E37_79B9 * (i + 1) ^ i;
      wr(12'h010, pat);
      rchk("R6 mask bit0", 12'h010, {31'd0, pat[0]});
      rchk("R7 mis", 12'h018, {31'd0, pat[0]});
      chk("R7 irq", {31'd0, irq}, {31'd0, pat[0]});
    end
    wr(12'h010, 32'h1);
    chk("R7 irq on", {31'd0, irq}, 1);
    // R8 clear with arbitrary data
    wr(12'h01C, 32'h0);
    rchk("R8 raw cleared", 12'h014, 0);
    chk("R8 irq cleared", {31'd0, irq}, 0);
    // R5 immediate match
    wr(12'h008, 32'h2000);
    wr(12'h004, 32'h2000);
    rchk("R5 match write fires", 12'h014, 1);
    chk("R5 irq", {31'd0, irq}, 1);
    wr(12'h01C, 32'hDEAD_BEEF);
    rchk("R8 clear any data", 12'h014, 0);
    wr(12'h004, 32'h3000);
    rchk("R5 no fire on mismatch", 12'h014, 0);
    wr(12'h008, 32'h3000);
    rchk("R5 load write fires", 12'h014, 1);
    wr(12'h01C, 32'h5);
    // R8 set beats clear on same edge
    wr(12'h004, 32'h4001);
    wr(12'h008, 32'h4000);
    repeat (D-1) @(negedge clk);
    wr(12'h01C, 32'h1);
    rchk("R8 set wins count", 12'h000, 32'h4001);
    rchk("R8 set wins raw", 12'h014, 1);
    wr(12'h01C, 32'h1);
    rchk("R8 later clear", 12'h014, 0);
    // R9 control write ignored
    wr(12'h00C, 32'h0);
    rchk("R9 ctrl still 1", 12'h00C, 1);
    rchk("R9 match kept", 12'h004, 32'h4001);
    // R10 ignored writes (D=4: edges 1..3 carry no tick)
    wr(12'h008, 32'h6000);
    wr(12'h000, 32'h5555);
    wr(12'h014, 32'h1);
    wr(12'h018, 32'h1);
    rchk("R10 count unchanged", 12'h000, 32'h6000);
    rchk("R10 raw unchanged", 12'h014, 0);
    rchk("R10 clr reads 0", 12'h01C, 0);
    // R12 wrap
    wr(12'h004, 32'h1);
    wr(12'h008, 32'hFFFF_FFFE);
    rchk("R12 no early fire", 12'h014, 0);
    repeat (D-1) @(negedge clk);
    rchk("R12 count top-1", 12'h000, 32'hFFFF_FFFE);
    @(negedge clk);
    rchk("R2 count top", 12'h000, 32'hFFFF_FFFF);
    repeat (D) @(negedge clk);
    rchk("R2 wrap to 0", 12'h000, 0);
    rchk("R12 not at 0", 12'h014, 0);
    repeat (D) @(negedge clk);
    rchk("R12 count 1", 12'h000, 1);
    rchk("R12 fired after wrap", 12'h014, 1);
    // R10 unmapped write ignored (lands at edge 1 after a tick)
    wr(12'h800, 32'hFFFF_FFFF);
    wr(12'hFE0, 32'hFFFF_FFFF);
    // full window sweep, state frozen inside one low phase (R10, R11)
    for (int w = 0; w < 1024; w++) begin
      logic [31:0] e;
      case (w)
        0: e = 1;
        1: e = 1;
        2: e = 32'hFFFF_FFFE;
        3: e = 1;
        4: e = 1;
        5: e = 1;
        6: e = 1;
        default: e = (w >= 1016) ? id_exp(w - 1016) : 0;
      endcase
      rchk((w >= 1016) ? "R11 id byte" : "R10 window word", 12'(w * 4), e);
    end
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule